// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the column addresses an SDRAM reads or writes, one per clock. A request gives a starting column, a three-bit length code and an ordering select (sequential or interleaved). The block then steps through the burst. Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned group of columns whose size equals the burst length. The column bits above that group are held, and the low bits wrap around inside the group. A full-page burst walks through the page in sequential order, wraps at the page end and runs until a terminate strobe stops it. A terminate strobe can also cut a fixed burst short.

A small state machine controls the block:
- ST_IDLE waits for a request.
- ST_FIXED steps through a burst of 1 to 8 beats.
- ST_PAGE steps through an open-ended full-page burst.
- ST_FAULT marks a request whose mode cannot be used.

The transitions are:
- idle to fixed, on a start with a valid length code of 1 to 8 beats.
- idle to page, on a start with the full-page code and sequential order.
- idle to fault, on a start with a reserved code, or with full page and interleaved order.
- fixed to idle, on the final beat or on terminate.
- page to idle, on terminate.
- fault to idle, always after one cycle.

Two parameters set the widths: COL_W is the width of the column address and PAGE_W is the number of low column bits that address a page.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released with no request, valid_o, last_o and err_o are low.
- R2: A start in idle with length code 000, 001, 010 or 011 gives 1, 2, 4 or 8 beats. Beat 0 (the start column) appears in the cycle after the clock edge that samples start_i, and each following clock gives the next beat with valid_o high. valid_o is low in the cycle after the last beat.
- R3: In sequential order (ilv_i = 0), beat i of a length-N burst has low log2(N) bits equal to (start low bits + i) mod N. The upper column bits equal those of the start column.
- R4: In interleaved order (ilv_i = 1), beat i has low log2(N) bits equal to (start low bits XOR i). The upper column bits are unchanged.
- R5: last_o is high on the final beat of a fixed-length burst that is not terminated, and low on every other cycle. This includes every beat of a full-page burst.
- R6: Length code 111 with ilv_i = 0 starts a full-page burst. Beat i has low PAGE_W bits equal to (start + i) mod 2^PAGE_W, and the upper bits are held. The burst continues until terminate.
- R7: If term_i is high in a cycle that shows a beat, that beat is the last one: valid_o is low in the next cycle.
- R8: A start with length code 100, 101 or 110, or with code 111 and ilv_i = 1, produces no beats. err_o is high for exactly the one cycle after the start edge.
- R9: A start_i pulse during a burst is ignored. The running burst continues with its own sequence, and no new burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request, sampled in idle |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Terminate strobe; ends the burst on the current beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is shown on col_o |
| last_o | output | 1 | Final beat of an untruncated fixed burst |
| err_o | output | 1 | One-cycle pulse for a request with an unusable mode |

## Verification
The hardest cases to reach from the ports are the wrap points: the cycle where a burst crosses the edge of its aligned group, and where a full-page burst crosses the page end. The stimulus places start columns just below those edges. For example, 0x2FC with an 8-bit page wraps to 0x200 after four beats, and group offsets of 5 and 3 wrap partway through 8-beat and 4-beat bursts. A terminate strobe is raised on a chosen beat, timed from the falling edge at which that beat is visible. A second start is driven inside a running burst to show that it has no effect.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIXED,
        ST_PAGE,
        ST_FAULT
    } colgen_state_e;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int PAGE_W = 8
) (
    input  logic [2:0]       len_code,
    input  logic             ilv,
    output logic [COL_W-1:0] wrap_mask,
    output logic             is_page,
    output logic             bad_mode
);

    localparam logic [COL_W-1:0] PAGE_MASK = COL_W'((64'd1 << PAGE_W) - 64'd1);

    always_comb begin
        wrap_mask = '0;
        is_page   = 1'b0;
        bad_mode  = 1'b0;
        case (len_code)
            LEN_1:    wrap_mask = COL_W'(0);
            LEN_2:    wrap_mask = COL_W'(1);
            LEN_4:    wrap_mask = COL_W'(3);
            LEN_8:    wrap_mask = COL_W'(7);
            LEN_PAGE: begin
                wrap_mask = PAGE_MASK;
                is_page   = 1'b1;
                bad_mode  = ilv;
            end
            default:  bad_mode = 1'b1;
        endcase
    end

    initial begin
        assert_page_fits_R6: assert (PAGE_W >= 3 && PAGE_W <= COL_W);
    end

endmodule

// File: rtl/colgen_addr_gen.sv
module colgen_addr_gen #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;
    logic [COL_W-1:0] low_sel;

    always_comb begin
        low_seq = (base_col + beat) & wrap_mask;
        low_ilv = (base_col ^ beat) & wrap_mask;
        low_sel = ilv ? low_ilv : low_seq;
        col     = (base_col & ~wrap_mask) | low_sel;
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int PAGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);

    colgen_state_e    state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] beat_q, beat_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             ilv_q, ilv_d;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_bad;
    logic             final_beat;

    colgen_mode_dec #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_dec (
        .len_code  (len_code_i),
        .ilv       (ilv_i),
        .wrap_mask (dec_mask),
        .is_page   (dec_page),
        .bad_mode  (dec_bad)
    );

    colgen_addr_gen #(.COL_W(COL_W)) u_addr (
        .base_col  (base_q),
        .beat      (beat_q),
        .wrap_mask (mask_q),
        .ilv       (ilv_q),
        .col       (col_o)
    );

    assign final_beat = (beat_q == mask_q);

    // next-state and datapath load
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        mask_d  = mask_q;
        ilv_d   = ilv_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    base_d = start_col_i;
                    beat_d = '0;
                    mask_d = dec_mask;
                    ilv_d  = ilv_i;
                    if (dec_bad)       state_d = ST_FAULT;
                    else if (dec_page) state_d = ST_PAGE;
                    else               state_d = ST_FIXED;
                end
            end
            ST_FIXED: begin
                if (term_i || final_beat) state_d = ST_IDLE;
                else                      beat_d  = beat_q + COL_W'(1);
            end
            ST_PAGE: begin
                if (term_i) state_d = ST_IDLE;
                else        beat_d  = (beat_q + COL_W'(1)) & mask_q;
            end
            ST_FAULT: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
            mask_q  <= mask_d;
            ilv_q   <= ilv_d;
        end
    end

    // outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        err_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FIXED: begin
                valid_o = 1'b1;
                last_o  = final_beat && !term_i;
            end
            ST_PAGE:  valid_o = 1'b1;
            ST_FAULT: err_o   = 1'b1;
        endcase
    end

    assert_no_beat_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o));

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o && !valid_o);

    assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    assert_term_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i) |=> !valid_o);

    assert_burst_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !term_i && !last_o) |=> valid_o);

    assert_upper_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (((col_o ^ $past(col_o)) & ~mask_q) == '0));

endmodule

// File: tb/sdram_burst_colgen_bench.sv
`timescale 1ns/1ps
module sdram_burst_colgen_bench;

    localparam int COL_W  = 10;
    localparam int PAGE_W = 8;
    localparam int PMASK  = (1 << PAGE_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    col;
        bit    last;
        string req;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    sdram_burst_colgen #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_sdram_burst_colgen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: pops one expected beat per shown beat
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected beat", int'(col_o), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(col_o) == e.col, e.req, "column", int'(col_o), e.col);
                check(last_o == e.last, "R5", "last flag", int'(last_o), int'(e.last));
            end
        end
    end

    // fixed burst: code 0..3, term_at < 0 means run to the end
    task automatic fixed_burst(int col, int code, bit ilv, int term_at, bit poke, string req);
        int len, beats, low, base;
        len   = 1 << code;
        beats = (term_at >= 0) ? term_at + 1 : len;
        low   = col & (len - 1);
        base  = col & ~(len - 1) & ((1 << COL_W) - 1);
        for (int i = 0; i < beats; i++) begin
            exp_t e;
            e.col  = base | (ilv ? (low ^ i) : ((low + i) % len));
            e.last = (term_at < 0) && (i == len - 1);
            e.req  = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
        start_i     = 1'b1;
        start_col_i = COL_W'(col);
        len_code_i  = 3'(code);
        ilv_i       = ilv;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < beats; i++) begin
            if (i == term_at) term_i = 1'b1;
            if (poke && i == 1) begin
                start_i     = 1'b1;
                start_col_i = COL_W'(col ^ 12'h155);
                len_code_i  = 3'd0;
            end
            @(negedge clk);
            term_i  = 1'b0;
            start_i = 1'b0;
        end
        check(valid_o == 1'b0, req, "valid after burst", int'(valid_o), 0);
        check(exp_q.size() == 0, req, "beats left", exp_q.size(), 0);
    endtask

    task automatic page_burst(int col, int beats);
        int base;
        base = col & ~PMASK & ((1 << COL_W) - 1);
        for (int i = 0; i < beats; i++) begin
            exp_t e;
            e.col  = base | ((col + i) & PMASK);
            e.last = 1'b0;
            e.req  = "R6";
            exp_q.push_back(e);
        end
        @(negedge clk);
        start_i     = 1'b1;
        start_col_i = COL_W'(col);
        len_code_i  = 3'b111;
        ilv_i       = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < beats; i++) begin
            if (i == beats - 1) term_i = 1'b1;
            @(negedge clk);
            term_i = 1'b0;
        end
        check(valid_o == 1'b0, "R7", "valid after page terminate", int'(valid_o), 0);
        check(exp_q.size() == 0, "R6", "beats left", exp_q.size(), 0);
    endtask

    task automatic bad_mode(int code, bit ilv);
        @(negedge clk);
        start_i     = 1'b1;
        start_col_i = COL_W'(10'h0F0);
        len_code_i  = 3'(code);
        ilv_i       = ilv;
        @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b1, "R8", "error pulse", int'(err_o), 1);
        check(valid_o == 1'b0, "R8", "no beat on error", int'(valid_o), 0);
        @(negedge clk);
        check(err_o == 1'b0, "R8", "error pulse width", int'(err_o), 0);
        check(valid_o == 1'b0, "R8", "no beat after error", int'(valid_o), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!valid_o && !last_o && !err_o, "R1", "outputs in reset",
              {29'd0, valid_o, last_o, err_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!valid_o && !last_o && !err_o, "R1", "outputs idle",
              {29'd0, valid_o, last_o, err_o}, 0);

        fixed_burst(12'h12D, 3, 1'b0, -1, 1'b0, "R3");
        fixed_burst(12'h12D, 3, 1'b1, -1, 1'b0, "R4");
        fixed_burst(12'h0A6, 2, 1'b0, -1, 1'b0, "R3");
        fixed_burst(12'h0A7, 2, 1'b1, -1, 1'b0, "R4");
        fixed_burst(12'h3FF, 1, 1'b0, -1, 1'b0, "R2");
        fixed_burst(12'h3FE, 1, 1'b1, -1, 1'b0, "R2");
        fixed_burst(12'h155, 0, 1'b0, -1, 1'b0, "R2");
        fixed_burst(12'h156, 0, 1'b1, -1, 1'b0, "R2");
        fixed_burst(12'h041, 3, 1'b0, 2, 1'b0, "R7");
        fixed_burst(12'h0C3, 3, 1'b0, -1, 1'b1, "R9");
        fixed_burst(12'h0C1, 1, 1'b1, -1, 1'b1, "R9");
        page_burst(12'h2FC, 7);
        page_burst(12'h010, 3);
        page_burst(12'h1FF, 1);
        bad_mode(4, 1'b0);
        bad_mode(5, 1'b1);
        bad_mode(6, 1'b0);
        bad_mode(7, 1'b1);
        fixed_burst(12'h3F9, 3, 1'b1, -1, 1'b0, "R4");

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule